// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block holds the supervisor timer compare register and, when the hypervisor option is built in, the guest (virtual-supervisor) timer compare register of a processor hart. Each register is compared against a free-running time value every cycle. The guest comparator adds a per-guest time offset before it compares. Each comparison drives an interrupt-pending level.

A single runtime enable from the machine environment configuration decides where the supervisor timer-pending bit comes from. When the enable is set, the bit is the hardware comparator output and software cannot write it. When the enable is clear, the bit is a plain software-written bit held in the interrupt-pending CSR logic, and only machine mode may touch the compare registers. A second enable from the hypervisor environment configuration gates the guest path in the same way. That second enable is forced to zero while the machine-level enable is clear.

The unit decodes CSR accesses to both compare registers. It checks them against the current privilege and virtualization state, returns read data for legal reads, and raises a one-cycle illegal-instruction pulse for rejected accesses. A rejected access never changes a register. A supervisor-register access from a virtualized supervisor is steered to the guest register.

Top module: `stimer_unit`

## Requirements
- R1: After reset both compare registers hold all ones, both pending outputs are 0 for any time below all ones, and `illegal_o` is 0.
- R2: `s_tmr_pend_o` is 1 exactly when `time_i >= s_cmp` as unsigned 64-bit values. It follows a change of `time_i` in the same cycle and follows a compare write from the clock edge that stores it.
- R3: `vs_tmr_pend_o` is 1 exactly when `(time_i + vs_time_off_i) mod 2^64 >= vs_cmp`, compared unsigned.
- R4: While `m_tmr_en_i` is 1, `s_tip_o` equals `s_tmr_pend_o` and `s_tip_wr_o` is 0.
- R5: While `m_tmr_en_i` is 0, `s_tip_o` equals `sw_s_tip_i` and `s_tip_wr_o` is 1, whatever the comparator says.
- R6: An access from machine mode (`priv_i` = 2'b11) to either register, at address 12'h14D (supervisor) or 12'h24D (guest), is always legal, whatever the enables. A legal read returns the register on `csr_rdata_o` in the same cycle, and a legal write is stored at the clock edge.
- R7: While `m_tmr_en_i` is 0, any access to either register from a mode other than machine mode is illegal and is not stored. While it is 1, a non-virtualized supervisor (`priv_i` = 2'b01, `virt_i` = 0) may access both registers.
- R8: Any access from user mode (`priv_i` = 2'b00) to either register is illegal.
- R9: `h_tmr_en_o` is `h_tmr_en_i AND m_tmr_en_i`, so the hypervisor-level enable reads as zero while the machine-level enable is clear.
- R10: While `h_tmr_en_o` is 1, `vs_tip_o` equals `vs_tmr_pend_o` and `vs_tip_wr_o` is 0. Otherwise `vs_tip_o` equals `sw_vs_tip_i` and `vs_tip_wr_o` is 1.
- R11: From a virtualized supervisor (`priv_i` = 2'b01, `virt_i` = 1) with `m_tmr_en_i` = 1, an access to 12'h14D goes to the guest register when `h_tmr_en_o` is 1 and is illegal when it is 0. An access to 12'h24D is always illegal.
- R12: `illegal_o` is 1 for exactly the one cycle after the edge that samples an illegal access strobe (`csr_we_i` or `csr_re_i` at a decoded address). It is never raised by a legal access or without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Free-running time value |
| vs_time_off_i | input | 64 | Guest time offset added before the guest compare |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_re_i | input | 1 | CSR read strobe |
| csr_wdata_i | input | 64 | CSR write data |
| csr_rdata_o | output | 64 | Read data for a legal read, 0 otherwise |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| virt_i | input | 1 | Current mode is virtualized |
| m_tmr_en_i | input | 1 | Machine-level timer compare enable |
| h_tmr_en_i | input | 1 | Stored hypervisor-level timer compare enable |
| sw_s_tip_i | input | 1 | Software-written supervisor timer pending bit |
| sw_vs_tip_i | input | 1 | Software-written guest timer pending bit |
| s_tmr_pend_o | output | 1 | Supervisor comparator result |
| vs_tmr_pend_o | output | 1 | Guest comparator result |
| s_tip_o | output | 1 | Effective supervisor timer pending bit |
| s_tip_wr_o | output | 1 | Supervisor timer pending bit is software-writable |
| vs_tip_o | output | 1 | Effective guest timer pending bit |
| vs_tip_wr_o | output | 1 | Guest timer pending bit is software-writable |
| h_tmr_en_o | output | 1 | Effective hypervisor-level enable as read back |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bench builds the unit with its defaults: the hypervisor option on, 64-bit time and the standard compare addresses. With the guest register, the offset adder and the virtualized-supervisor redirect all present, every enable combination and privilege case in the access rules can be reached. The full 64-bit width lets the unsigned compare near the top bit and the wrap of time plus offset be exercised directly. The build without the hypervisor option is left to elaboration only.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam int unsigned TIME_W = 64;
  localparam int unsigned ADDR_W = 12;
endpackage

// File: rtl/stimer_cmp_reg.sv
module stimer_cmp_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= wdata_i;
  end

  // A register only moves on a granted write; rejected accesses must not leak in.
  p_hold_without_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/stimer_cmp.sv
module stimer_cmp #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] off_i,
  input  logic [W-1:0] cmp_i,
  output logic         pend_o
);
  logic [W-1:0] eff_time;

  assign eff_time = time_i + off_i;  // wraps modulo 2^W
  assign pend_o   = (eff_time >= cmp_i);
endmodule

// File: rtl/stimer_access.sv
module stimer_access
  import stimer_pkg::*;
#(
  parameter int unsigned     AW      = 12,
  parameter logic [AW-1:0]   S_ADDR  = 12'h14D,
  parameter logic [AW-1:0]   VS_ADDR = 12'h24D,
  parameter bit              HAS_H   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          m_en_i,
  input  logic          h_en_i,
  output logic          s_we_o,
  output logic          vs_we_o,
  output logic          s_rd_o,
  output logic          vs_rd_o,
  output logic          illegal_o
);
  logic hit_s, hit_vs, acc, is_m, is_s;
  logic tgt_s, tgt_vs, bad;
  logic illegal_q;

  assign hit_s  = (addr_i == S_ADDR);
  assign hit_vs = HAS_H && (addr_i == VS_ADDR);
  assign acc    = (we_i | re_i) & (hit_s | hit_vs);
  assign is_m   = (priv_e'(priv_i) == PRIV_M);
  assign is_s   = (priv_e'(priv_i) == PRIV_S);

  always_comb begin
    tgt_s  = 1'b0;
    tgt_vs = 1'b0;
    bad    = 1'b0;
    if (is_m) begin
      tgt_s  = hit_s;
      tgt_vs = hit_vs;
    end else if (!is_s || !m_en_i) begin
      bad = 1'b1;
    end else if (!virt_i) begin
      tgt_s  = hit_s;
      tgt_vs = hit_vs;
    end else if (hit_vs) begin
      bad = 1'b1;
    end else if (HAS_H && h_en_i) begin
      tgt_vs = 1'b1;  // guest view of the supervisor register
    end else begin
      bad = 1'b1;
    end
  end

  assign s_we_o  = acc & we_i & tgt_s  & ~bad;
  assign vs_we_o = acc & we_i & tgt_vs & ~bad;
  assign s_rd_o  = acc & re_i & tgt_s  & ~bad;
  assign vs_rd_o = acc & re_i & tgt_vs & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= acc & bad;
  end
  assign illegal_o = illegal_q;

  p_pulse_needs_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_q |-> $past(we_i | re_i));
  p_machine_never_trapped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && is_m) |=> !illegal_q);
  p_user_always_trapped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && priv_e'(priv_i) == PRIV_U) |=> illegal_q);
  p_gated_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_en_i && !is_m) |-> !(s_we_o || vs_we_o));
endmodule

// File: rtl/stimer_unit.sv
module stimer_unit
  import stimer_pkg::*;
#(
  parameter int unsigned         TW      = TIME_W,
  parameter int unsigned         AW      = ADDR_W,
  parameter logic [AW-1:0]       S_ADDR  = 12'h14D,
  parameter logic [AW-1:0]       VS_ADDR = 12'h24D,
  parameter bit                  HAS_H   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] vs_time_off_i,
  input  logic [AW-1:0] csr_addr_i,
  input  logic          csr_we_i,
  input  logic          csr_re_i,
  input  logic [TW-1:0] csr_wdata_i,
  output logic [TW-1:0] csr_rdata_o,
  input  logic [1:0]    priv_i,
  input  logic          virt_i,
  input  logic          m_tmr_en_i,
  input  logic          h_tmr_en_i,
  input  logic          sw_s_tip_i,
  input  logic          sw_vs_tip_i,
  output logic          s_tmr_pend_o,
  output logic          vs_tmr_pend_o,
  output logic          s_tip_o,
  output logic          s_tip_wr_o,
  output logic          vs_tip_o,
  output logic          vs_tip_wr_o,
  output logic          h_tmr_en_o,
  output logic          illegal_o
);
  logic          h_eff;
  logic          s_we, vs_we, s_rd, vs_rd;
  logic [TW-1:0] s_cmp_q, vs_cmp_q;

  assign h_eff      = h_tmr_en_i & m_tmr_en_i;
  assign h_tmr_en_o = h_eff;

  stimer_access #(
    .AW(AW), .S_ADDR(S_ADDR), .VS_ADDR(VS_ADDR), .HAS_H(HAS_H)
  ) u_access (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(csr_addr_i), .we_i(csr_we_i), .re_i(csr_re_i),
    .priv_i(priv_i), .virt_i(virt_i),
    .m_en_i(m_tmr_en_i), .h_en_i(h_eff),
    .s_we_o(s_we), .vs_we_o(vs_we), .s_rd_o(s_rd), .vs_rd_o(vs_rd),
    .illegal_o(illegal_o)
  );

  stimer_cmp_reg #(.W(TW)) u_s_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(s_we), .wdata_i(csr_wdata_i), .q_o(s_cmp_q)
  );

  stimer_cmp #(.W(TW)) u_s_cmp (
    .time_i(time_i), .off_i('0), .cmp_i(s_cmp_q), .pend_o(s_tmr_pend_o)
  );

  generate
    if (HAS_H) begin : g_guest
      stimer_cmp_reg #(.W(TW)) u_vs_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(vs_we), .wdata_i(csr_wdata_i), .q_o(vs_cmp_q)
      );
      stimer_cmp #(.W(TW)) u_vs_cmp (
        .time_i(time_i), .off_i(vs_time_off_i), .cmp_i(vs_cmp_q), .pend_o(vs_tmr_pend_o)
      );
    end else begin : g_no_guest
      logic unused_guest;
      assign unused_guest  = ^{vs_we, vs_time_off_i};
      assign vs_cmp_q      = '1;
      assign vs_tmr_pend_o = 1'b0;
    end
  endgenerate

  always_comb begin
    csr_rdata_o = '0;
    if (s_rd)  csr_rdata_o = s_cmp_q;
    if (vs_rd) csr_rdata_o = vs_cmp_q;
  end

  // Pending source: comparator when enabled, software bit otherwise.
  assign s_tip_o     = m_tmr_en_i ? s_tmr_pend_o : sw_s_tip_i;
  assign s_tip_wr_o  = ~m_tmr_en_i;
  assign vs_tip_o    = h_eff ? vs_tmr_pend_o : sw_vs_tip_i;
  assign vs_tip_wr_o = ~h_eff;

  p_s_tip_from_cmp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tmr_en_i |-> (s_tip_o == s_tmr_pend_o && !s_tip_wr_o));
  p_s_tip_from_sw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tmr_en_i |-> (s_tip_o == sw_s_tip_i && s_tip_wr_o));
  p_h_en_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tmr_en_i |-> !h_tmr_en_o);
  p_vs_tip_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_tmr_en_o |-> (vs_tip_o == sw_vs_tip_i && vs_tip_wr_o));
  p_pend_monotonic_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(s_tmr_pend_o) && $stable(s_cmp_q) && time_i >= $past(time_i)) |-> s_tmr_pend_o);
endmodule

// File: tb/tb_stimer_unit.sv
module tb_stimer_unit;
  localparam time CLK_PERIOD = 10;
  localparam logic [11:0] A_S  = 12'h14D;
  localparam logic [11:0] A_VS = 12'h24D;
  localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [63:0] time_i = '0, vs_time_off_i = '0, csr_wdata_i = '0, csr_rdata_o;
  logic [11:0] csr_addr_i = '0;
  logic        csr_we_i = 0, csr_re_i = 0, virt_i = 0;
  logic [1:0]  priv_i = PM;
  logic        m_tmr_en_i = 0, h_tmr_en_i = 0, sw_s_tip_i = 0, sw_vs_tip_i = 0;
  logic        s_tmr_pend_o, vs_tmr_pend_o, s_tip_o, s_tip_wr_o;
  logic        vs_tip_o, vs_tip_wr_o, h_tmr_en_o, illegal_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stimer_unit dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, read data sampled before the edge,
  // illegal pulse sampled after the edge, then its fall one cycle later.
  task automatic access(input logic [11:0] a, input bit wr, input logic [63:0] wd,
                        input logic [1:0] p, input bit v,
                        output logic [63:0] rd, output logic ill, output logic ill_next);
    @(negedge clk_i);
    csr_addr_i = a; csr_we_i = wr; csr_re_i = !wr; csr_wdata_i = wd;
    priv_i = p; virt_i = v;
    #1 rd = csr_rdata_o;
    @(posedge clk_i); #1 ill = illegal_o;
    csr_we_i = 0; csr_re_i = 0; priv_i = PM; virt_i = 0;
    @(posedge clk_i); #1 ill_next = illegal_o;
  endtask

  task automatic m_read(input logic [11:0] a, output logic [63:0] rd);
    logic i0, i1;
    access(a, 0, '0, PM, 0, rd, i0, i1);
  endtask

  task automatic m_write(input logic [11:0] a, input logic [63:0] wd);
    logic [63:0] rd; logic i0, i1;
    access(a, 1, wd, PM, 0, rd, i0, i1);
  endtask

  task automatic t_reset;
    logic [63:0] rd;
    chk("R1 illegal idle", illegal_o, 0);
    chk("R1 s pend", s_tmr_pend_o, 0);
    chk("R1 vs pend", vs_tmr_pend_o, 0);
    m_read(A_S, rd);  chk("R1 s reg ones", rd, '1);
    m_read(A_VS, rd); chk("R1 vs reg ones", rd, '1);
  endtask

  task automatic t_s_compare;
    m_tmr_en_i = 1;
    m_write(A_S, 64'd100);
    @(negedge clk_i) time_i = 64'd99; #1
    chk("R2 below", s_tmr_pend_o, 0);
    chk("R4 tip follows cmp low", s_tip_o, 0);
    chk("R4 not writable", s_tip_wr_o, 0);
    @(negedge clk_i) time_i = 64'd100; #1 chk("R2 equal", s_tmr_pend_o, 1);
    chk("R4 tip follows cmp high", s_tip_o, 1);
    @(negedge clk_i) time_i = 64'h8000_0000_0000_0000; #1 chk("R2 unsigned top", s_tmr_pend_o, 1);
    m_write(A_S, 64'hFFFF_FFFF_FFFF_FFF0);
    #1 chk("R2 after write", s_tmr_pend_o, 0);
  endtask

  task automatic t_sw_path;
    m_write(A_S, 64'd10);
    @(negedge clk_i) m_tmr_en_i = 0; time_i = 64'd50; sw_s_tip_i = 0; #1
    chk("R5 cmp high but sw low", s_tip_o, 0);
    chk("R5 writable", s_tip_wr_o, 1);
    @(negedge clk_i) sw_s_tip_i = 1; #1 chk("R5 sw bit passes", s_tip_o, 1);
    sw_s_tip_i = 0;
  endtask

  task automatic t_gating;
    logic [63:0] rd; logic i0, i1;
    m_tmr_en_i = 0;
    access(A_S, 1, 64'd5, PS, 0, rd, i0, i1);
    chk("R7 gated S write illegal", i0, 1);
    chk("R12 pulse one cycle", i1, 0);
    m_read(A_S, rd); chk("R7 gated write dropped", rd, 64'd10);
    access(A_S, 1, 64'd200, PM, 0, rd, i0, i1);
    chk("R6 M write legal while gated", i0, 0);
    m_read(A_S, rd); chk("R6 M write stored", rd, 64'd200);
    access(A_VS, 0, '0, PM, 0, rd, i0, i1);
    chk("R6 M read guest while gated", rd, '1);
    @(negedge clk_i) m_tmr_en_i = 1;
    access(A_S, 1, 64'd300, PS, 0, rd, i0, i1);
    chk("R7 S write legal when enabled", i0, 0);
    m_read(A_S, rd); chk("R7 S write stored", rd, 64'd300);
    @(negedge clk_i) csr_addr_i = A_S; #1
    @(posedge clk_i); #1 chk("R12 no strobe no pulse", illegal_o, 0);
  endtask

  task automatic t_user;
    logic [63:0] rd; logic i0, i1;
    access(A_S, 0, '0, PU, 0, rd, i0, i1);
    chk("R8 user read illegal", i0, 1);
    chk("R8 user read no data", rd, 0);
  endtask

  task automatic t_h_en;
    @(negedge clk_i) m_tmr_en_i = 1; h_tmr_en_i = 1; #1
    chk("R9 both set", h_tmr_en_o, 1);
    @(negedge clk_i) m_tmr_en_i = 0; #1
    chk("R9 masked by machine enable", h_tmr_en_o, 0);
    @(negedge clk_i) m_tmr_en_i = 1;
  endtask

  task automatic t_vs;
    m_write(A_VS, 64'd1000);
    @(negedge clk_i) time_i = 64'd900; vs_time_off_i = 64'd100; #1
    chk("R3 offset reaches cmp", vs_tmr_pend_o, 1);
    chk("R10 tip follows guest cmp", vs_tip_o, 1);
    chk("R10 not writable", vs_tip_wr_o, 0);
    @(negedge clk_i) vs_time_off_i = 64'd99; #1 chk("R3 one short", vs_tmr_pend_o, 0);
    @(negedge clk_i) time_i = '1; vs_time_off_i = 64'd2; #1 chk("R3 sum wraps", vs_tmr_pend_o, 0);
    @(negedge clk_i) time_i = 64'd2000; h_tmr_en_i = 0; sw_vs_tip_i = 0; #1
    chk("R10 sw bit when disabled", vs_tip_o, 0);
    chk("R10 writable when disabled", vs_tip_wr_o, 1);
    @(negedge clk_i) h_tmr_en_i = 1;
  endtask

  task automatic t_redirect;
    logic [63:0] rd; logic i0, i1;
    access(A_S, 1, 64'd77, PS, 1, rd, i0, i1);
    chk("R11 redirect legal", i0, 0);
    m_read(A_VS, rd); chk("R11 guest reg written", rd, 64'd77);
    m_read(A_S, rd);  chk("R11 supervisor reg kept", rd, 64'd300);
    access(A_S, 0, '0, PS, 1, rd, i0, i1);
    chk("R11 redirect read", rd, 64'd77);
    access(A_VS, 0, '0, PS, 1, rd, i0, i1);
    chk("R11 guest addr from guest illegal", i0, 1);
    @(negedge clk_i) h_tmr_en_i = 0;
    access(A_S, 1, 64'd5, PS, 1, rd, i0, i1);
    chk("R11 redirect blocked illegal", i0, 1);
    m_read(A_VS, rd); chk("R11 blocked write dropped", rd, 64'd77);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    t_reset();
    t_s_compare();
    t_sw_path();
    t_gating();
    t_user();
    t_h_en();
    t_vs();
    t_redirect();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1..: watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule